// File: doc/BRIEF.md
# Still-Frame Camera Capture Controller

This block stores a single still frame from a camera's parallel byte stream into an external asynchronous SRAM. It does not use the camera's pixel clock. It watches only the vertical sync and horizontal reference levels, sampled by a local clock that runs at twice the pixel rate. Each stored byte therefore takes two local cycles. In the first cycle the write strobe is low. In the second cycle the strobe is high and the address advances.

A capture starts with a one-cycle start request. The controller then arms and waits for a falling edge on vertical sync. From that point, every rising edge of the line reference opens a line, and bytes are written to consecutive addresses for as long as the reference stays high. While the line reference is low between lines, a rising edge on vertical sync ends the capture. The controller then holds its done flag, the byte count and the final address until the next start request.

An optional line-skip input stores only the even-numbered lines, so a frame at full byte rate fits in half the memory. When the memory is full, the address stays on the last location, further bytes are dropped, and an overflow flag is raised.

Top module: `frame_grab_ctrl`

## Requirements
- R1: After reset, `done`, `overflow`, `sram_addr` and `byte_count` are 0, `sram_we_n` is 1, and no write strobe occurs until a start request is accepted.
- R2: Each stored byte takes exactly two clocks. `sram_we_n` is low for one clock, and in the following clock it is high and the address advances by one.
- R3: Bytes are written while the line reference stays high. A line reference held high for 2N clocks stores exactly N bytes.
- R4: A rising line reference after a gap starts a new line at the address after the last byte written. The first line of a capture starts at address 0.
- R5: A capture begins only after a high-to-low transition of vertical sync that is seen after the start request. Lines that arrive while vertical sync was already low at the start request are not stored.
- R6: A rising edge of vertical sync during a line gap ends the capture and raises `done`. If vertical sync and the line reference rise in the same cycle, the capture ends and no byte is written.
- R7: While `done` is high, no write strobe occurs and `byte_count` does not change, whatever the sync inputs do. A start request clears `done`, `overflow`, `byte_count` and the address.
- R8: With `skip_en` high, lines are numbered from 0 within the frame and only the even-numbered lines are written. Odd lines produce no strobe and do not advance the address.
- R9: `byte_count` equals the number of write strobes issued since the last start request.
- R10: Once MEM_DEPTH bytes have been written, `sram_addr` holds at MEM_DEPTH-1, `byte_count` holds at MEM_DEPTH, later bytes produce no strobe, and `overflow` goes high.
- R11: `sram_addr` changes only in a cycle that follows a cycle with `sram_we_n` high.
- R12: `sram_dq` carries `pix_in` delayed by two clocks, so that it lines up with the synchronised timing inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock at twice the pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle capture request |
| vsync_in | input | 1 | Camera vertical sync (asynchronous) |
| href_in | input | 1 | Camera line reference (asynchronous) |
| skip_en | input | 1 | Store only even-numbered lines |
| pix_in | input | DATA_W | Camera byte stream |
| sram_addr | output | ADDR_W | SRAM address |
| sram_we_n | output | 1 | Active-low SRAM write strobe |
| sram_dq | output | DATA_W | Data driven to the SRAM |
| done | output | 1 | Frame captured, held until the next start |
| overflow | output | 1 | Bytes were dropped because the memory was full |
| byte_count | output | ADDR_W+1 | Bytes stored in this capture |

## Verification
Two edge decisions can fall in the same cycle during a line gap: the end of the frame on rising vertical sync and the start of a new line on rising line reference. The bench drives both inputs high on the same clock after a stored line. It then checks that `done` rises, that no further strobe appears, and that the byte count still equals the bytes of the earlier line. A second coincidence is tested as well: memory saturation in the middle of a line, where the strobe must stop at the last address while the line reference remains high.

// File: rtl/frame_grab_ctrl.sv
module frame_grab_ctrl #(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int MEM_DEPTH = 1 << ADDR_W,
  localparam int CNT_W    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              vsync_in,
  input  logic              href_in,
  input  logic              skip_en,
  input  logic [DATA_W-1:0] pix_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq,
  output logic              done,
  output logic              overflow,
  output logic [CNT_W-1:0]  byte_count
);

  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(MEM_DEPTH - 1);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_GAP, S_WR, S_ADV, S_SKIP, S_DONE} st_t;

  st_t st;
  logic vs_m, vs_s, vs_q, hr_m, hr_s, hr_q;
  logic full, odd;
  logic [DATA_W-1:0] pix_m;

  wire vs_rise = vs_s & ~vs_q;
  wire vs_fall = ~vs_s & vs_q;
  wire hr_rise = hr_s & ~hr_q;

  assign sram_we_n = !(st == S_WR && !full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {vs_m, vs_s, vs_q, hr_m, hr_s, hr_q} <= '0;
      pix_m <= '0; sram_dq <= '0;
      st <= S_IDLE; sram_addr <= '0; byte_count <= '0;
      done <= 1'b0; overflow <= 1'b0; full <= 1'b0; odd <= 1'b0;
    end else begin
      vs_m <= vsync_in; vs_s <= vs_m; vs_q <= vs_s;
      hr_m <= href_in;  hr_s <= hr_m; hr_q <= hr_s;
      pix_m <= pix_in;  sram_dq <= pix_m;
      case (st)
        S_IDLE, S_DONE:
          if (start) begin
            st <= S_ARM; sram_addr <= '0; byte_count <= '0;
            done <= 1'b0; overflow <= 1'b0; full <= 1'b0; odd <= 1'b0;
          end
        S_ARM:
          if (vs_fall) st <= S_GAP;
        S_GAP:
          if (vs_rise) begin
            st <= S_DONE; done <= 1'b1;
          end else if (hr_rise) begin
            odd <= ~odd;
            st  <= (skip_en && odd) ? S_SKIP : S_WR;
          end
        S_SKIP:
          if (!hr_s) st <= S_GAP;
        S_WR: begin
          st <= S_ADV;
          if (full) overflow <= 1'b1;
          else begin
            byte_count <= byte_count + 1'b1;
            if (sram_addr == TOP) full <= 1'b1;
          end
        end
        S_ADV: begin
          if (!full) sram_addr <= sram_addr + 1'b1;
          st <= hr_s ? S_WR : S_GAP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_setup_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_addr != $past(sram_addr)) |-> $past(sram_we_n));
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> sram_we_n);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && sram_addr != TOP) |=> ##1 (sram_addr == $past(sram_addr, 2) + 1'b1 || done));
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sram_we_n);
  p_no_write_after_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> sram_we_n);
  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_count <= CNT_W'(MEM_DEPTH));

endmodule

// File: tb/tb_frame_grab_ctrl.sv
module tb_frame_grab_ctrl;
  localparam int AW = 5, DW = 8, DEPTH = 32;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, vsync_in = 1'b1, href_in = 1'b0, skip_en = 1'b0;
  logic [DW-1:0] pix_in = '0;
  logic [AW-1:0] sram_addr;
  logic sram_we_n, done, overflow;
  logic [DW-1:0] sram_dq;
  logic [AW:0] byte_count;

  int checks = 0, fails = 0, writes = 0;
  logic [DW-1:0] cur_tag = '0;

  frame_grab_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MEM_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vsync_in(vsync_in), .href_in(href_in),
    .skip_en(skip_en), .pix_in(pix_in), .sram_addr(sram_addr), .sram_we_n(sram_we_n),
    .sram_dq(sram_dq), .done(done), .overflow(overflow), .byte_count(byte_count));

  always #10 clk = ~clk;

  // {skip_en, lines, bytes per line, expected bytes}
  localparam int VEC [4][4] = '{'{0, 3, 5, 15}, '{1, 4, 5, 10}, '{1, 5, 3, 9}, '{0, 2, 1, 2}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1; writes = 0;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic line(input int nbytes, input logic [DW-1:0] tag);
    @(negedge clk); cur_tag = tag; pix_in = tag; href_in = 1'b1;
    idle(2 * nbytes - 1);
    @(negedge clk); href_in = 1'b0;
    idle(6);
  endtask

  task automatic frame(input bit skip, input int lines, input int bpl, input int base);
    skip_en = skip; vsync_in = 1'b1; idle(3);
    pulse_start(); idle(3);
    vsync_in = 1'b0; idle(6);
    for (int l = 0; l < lines; l++) line(bpl, DW'(base + l));
    vsync_in = 1'b1; idle(6);
  endtask

  // R2 R4 R12: every strobe lands on the next address and carries the line's byte
  always @(negedge clk) begin
    if (rst_n && !sram_we_n) begin
      check(sram_addr == AW'(writes), "R4 address sequence", sram_addr, writes);
      check(sram_dq == cur_tag, "R12 data pass-through", sram_dq, cur_tag);
      writes++;
    end
  end

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(2);
    // R1 reset state
    check(done == 0 && overflow == 0, "R1 flags at reset", {done, overflow}, 0);
    check(sram_addr == 0 && byte_count == 0, "R1 counters at reset", byte_count, 0);
    check(sram_we_n == 1, "R1 strobe idle", sram_we_n, 1);
    rst_n = 1'b1; idle(2);
    vsync_in = 1'b0; idle(4); line(3, 8'h11); vsync_in = 1'b1; idle(4);
    check(writes == 0, "R1 no write before start", writes, 0);

    // table walk: R3 R8 R9 R6
    for (int v = 0; v < 4; v++) begin
      frame(VEC[v][0] != 0, VEC[v][1], VEC[v][2], 16 * (v + 1));
      check(done == 1, "R6 done after vsync rise", done, 1);
      check(byte_count == (AW+1)'(VEC[v][3]), "R3 R8 byte count", byte_count, VEC[v][3]);
      check(writes == VEC[v][3], "R9 strobes equal count", writes, VEC[v][3]);
      check(sram_addr == AW'(VEC[v][3]), "R2 final address", sram_addr, VEC[v][3]);
      check(overflow == 0, "R10 no overflow", overflow, 0);
    end

    // R7: lines after done are ignored
    vsync_in = 1'b0; idle(4); line(4, 8'h77); vsync_in = 1'b1; idle(4);
    check(writes == 2 && byte_count == 2, "R7 no write while done", writes, 2);
    check(done == 1, "R7 done held", done, 1);

    // R5: start while vsync already low, first line must be ignored
    vsync_in = 1'b0; idle(4);
    pulse_start(); idle(2);
    check(done == 0 && byte_count == 0, "R7 start clears state", byte_count, 0);
    line(4, 8'h55);
    check(writes == 0, "R5 mid-frame line ignored", writes, 0);
    vsync_in = 1'b1; idle(4); vsync_in = 1'b0; idle(4);
    line(3, 8'h56);
    vsync_in = 1'b1; idle(6);
    check(byte_count == 3 && done == 1, "R5 capture after vsync fall", byte_count, 3);

    // R6: vsync and href rise in the same cycle
    skip_en = 1'b0; vsync_in = 1'b1; idle(3); pulse_start(); idle(3);
    vsync_in = 1'b0; idle(6);
    line(2, 8'h61);
    @(negedge clk); vsync_in = 1'b1; href_in = 1'b1; cur_tag = 8'hEE;
    idle(8); href_in = 1'b0; idle(4);
    check(done == 1, "R6 collision ends frame", done, 1);
    check(byte_count == 2 && writes == 2, "R6 collision writes nothing", writes, 2);

    // R6: empty frame
    frame(0, 0, 1, 0);
    check(done == 1 && byte_count == 0, "R6 empty frame", byte_count, 0);

    // R10: saturation in the middle of a line
    frame(0, 3, 12, 8'h90);
    check(overflow == 1, "R10 overflow flag", overflow, 1);
    check(byte_count == DEPTH, "R10 count saturates", byte_count, DEPTH);
    check(writes == DEPTH, "R10 strobes stop at top", writes, DEPTH);
    check(sram_addr == AW'(DEPTH - 1), "R10 address holds", sram_addr, DEPTH - 1);

    // R7: start clears overflow
    pulse_start(); idle(2);
    check(overflow == 0 && sram_addr == 0, "R7 start clears overflow", overflow, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule